// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Idle Gating

This block watches for a stuck program. The system clock is first divided by a machine-cycle divider (twelve clocks per tick by default). A power-of-two prescaler, chosen by a 3-bit select, then divides it further and feeds a wide up-counter. If software does not restart the counter before it wraps, and the watchdog is enabled, the block raises a reset pulse lasting two machine cycles. After the pulse the count starts again from zero.

Software drives a small register-style port with one write strobe. The strobe loads an enable bit, an idle-run bit and the prescaler select. It can also set a clear bit, which takes effect at the next machine-cycle boundary and then drops by itself. An idle input from the power manager stops the count unless idle-run is set. The synchronous external reset returns the block to a disabled, zeroed state.

Top module: `wdog_prescaled`

## Requirements
- R1: While `ext_rst` is high and in the cycle after it is released, `wd_rst_o` and `clr_pending_o` are 0. The watchdog is disabled, and the select, the prescaler and the counter are all zero.
- R2: After a clear takes effect, the next overflow raises `wd_rst_o` exactly 2^CNT_W × 2^(sel+1) × MC_DIV clock cycles later. Here sel is the binary `cfg_ps_sel` value 0..7, which gives a prescaler of 2, 4, ..., 256.
- R3: A write with `cfg_clr`=1 makes `clr_pending_o` read 1 from the next cycle. At the next machine-cycle boundary, which comes at most MC_DIV cycles later, the prescaler and the counter are zeroed and `clr_pending_o` returns to 0 on its own.
- R4: If clears are written at intervals shorter than the timeout, no reset pulse appears.
- R5: When the enable bit is 0, an overflow produces no pulse on `wd_rst_o`.
- R6: While `idle_i`=1 and the idle-run bit is 0, the counter holds its value. With idle-run set to 1, the counter keeps counting in idle.
- R7: Each reset pulse stays high for exactly PULSE_MC × MC_DIV clock cycles, which is 2 machine cycles.
- R8: A new prescaler select written while counting takes effect only from the next prescaler terminal count. The prescaler never counts past the terminal value of the select that is currently active.
- R9: After a pulse ends, the count restarts from zero. The gap from the end of one pulse to the start of the next is exactly one full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst | input | 1 | Synchronous external reset, active high |
| idle_i | input | 1 | Processor is in idle mode |
| cfg_we | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable bit written on strobe |
| cfg_clr | input | 1 | Writing 1 requests a counter restart |
| cfg_idle_run | input | 1 | Keep counting while idle |
| cfg_ps_sel | input | PS_SEL_W | Prescaler select, 2^(sel+1) |
| clr_pending_o | output | 1 | Clear bit readback, self-clearing |
| wd_rst_o | output | 1 | Internal reset pulse |

## Verification
The checks assume that `ext_rst` is held for at least one full clock. They also assume that no write lands while a reset pulse is high, and that software leaves the select alone during the first prescaler period whenever an exact timeout is being measured. The stimulus follows these rules. Every run begins with a reset. Each write is a single-cycle strobe driven between clock edges. The bench always waits for the pulse to fall before it writes again. A select change is issued only a few cycles after a clear completes, well inside the first prescaler period.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int MC_DIV   = 12,
  parameter int CNT_W    = 14,
  parameter int PS_SEL_W = 3,
  parameter int PULSE_MC = 2
) (
  input  logic                clk,
  input  logic                ext_rst,
  input  logic                idle_i,
  input  logic                cfg_we,
  input  logic                cfg_en,
  input  logic                cfg_clr,
  input  logic                cfg_idle_run,
  input  logic [PS_SEL_W-1:0] cfg_ps_sel,
  output logic                clr_pending_o,
  output logic                wd_rst_o
);
  localparam int MC_W      = $clog2(MC_DIV);
  localparam int PS_W      = 1 << PS_SEL_W;
  localparam int PULSE_CLK = PULSE_MC * MC_DIV;
  localparam int PL_W      = $clog2(PULSE_CLK + 1);

  logic [MC_W-1:0]     mc_cnt;
  logic [PS_W-1:0]     ps_cnt;
  logic [CNT_W-1:0]    cnt_q;
  logic [PL_W-1:0]     pulse_left;
  logic [PS_SEL_W-1:0] sel_q, sel_act;
  logic                en_q, idle_run_q, clr_q;

  logic [PS_W:0]   two_pow;
  logic [PS_W-1:0] ps_term;
  logic mc_tick, hold, run, clr_fire, ps_end, ps_tick, ovf;

  assign mc_tick  = (mc_cnt == MC_W'(MC_DIV - 1));
  assign hold     = (pulse_left != '0);
  assign run      = !idle_i || idle_run_q;
  assign clr_fire = clr_q && mc_tick;
  assign two_pow  = (PS_W+1)'(2) << sel_act;
  assign ps_term  = PS_W'(two_pow - (PS_W+1)'(1));
  assign ps_end   = (ps_cnt == ps_term);
  assign ps_tick  = mc_tick && run && !hold && !clr_fire && ps_end;
  assign ovf      = ps_tick && (&cnt_q);

  assign clr_pending_o = clr_q;
  assign wd_rst_o      = hold;

  always_ff @(posedge clk) begin
    if (ext_rst) begin
      mc_cnt     <= '0;
      ps_cnt     <= '0;
      cnt_q      <= '0;
      pulse_left <= '0;
      sel_q      <= '0;
      sel_act    <= '0;
      en_q       <= 1'b0;
      idle_run_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      mc_cnt <= mc_tick ? '0 : mc_cnt + 1'b1;

      if (cfg_we) begin
        en_q       <= cfg_en;
        idle_run_q <= cfg_idle_run;
        sel_q      <= cfg_ps_sel;
      end

      if (cfg_we && cfg_clr) clr_q <= 1'b1;
      else if (clr_fire)     clr_q <= 1'b0;

      if (clr_fire || hold) begin
        ps_cnt  <= '0;
        cnt_q   <= '0;
        sel_act <= sel_q;
      end else if (mc_tick && run) begin
        if (ps_end) begin
          ps_cnt  <= '0;
          cnt_q   <= cnt_q + 1'b1;
          sel_act <= sel_q;
        end else begin
          ps_cnt <= ps_cnt + 1'b1;
        end
      end

      if (ovf && en_q) pulse_left <= PL_W'(PULSE_CLK);
      else if (hold)   pulse_left <= pulse_left - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int MC_DIV   = 12,
  parameter int CNT_W    = 14,
  parameter int PS_SEL_W = 3,
  parameter int PULSE_MC = 2
) (
  input logic                       clk,
  input logic                       ext_rst,
  input logic                       idle_i,
  input logic                       cfg_we,
  input logic                       cfg_clr,
  input logic                       wd_rst_o,
  input logic                       en_q,
  input logic                       idle_run_q,
  input logic                       clr_q,
  input logic                       mc_tick,
  input logic                       hold,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [(1<<PS_SEL_W)-1:0]   ps_cnt,
  input logic [(1<<PS_SEL_W)-1:0]   ps_term
);
  localparam int PULSE_CLK = PULSE_MC * MC_DIV;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (ext_rst)       hi_cnt <= '0;
    else if (wd_rst_o) hi_cnt <= hi_cnt + 16'd1;
    else               hi_cnt <= '0;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (ext_rst)
    $fell(ext_rst) |-> (!wd_rst_o && !clr_q && !en_q && cnt_q == '0));

  assert_clear_selfclears_R3: assert property (@(posedge clk) disable iff (ext_rst)
    (clr_q && mc_tick && !(cfg_we && cfg_clr) && !hold) |=> (!clr_q && cnt_q == '0));

  assert_no_pulse_disabled_R5: assert property (@(posedge clk) disable iff (ext_rst)
    $rose(wd_rst_o) |-> $past(en_q));

  assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (ext_rst)
    (idle_i && !idle_run_q && !clr_q && !hold && !cfg_we) |=> ($stable(cnt_q) && $stable(ps_cnt)));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (ext_rst)
    $fell(wd_rst_o) |-> (hi_cnt == 16'(PULSE_CLK)));

  assert_ps_bounded_R8: assert property (@(posedge clk) disable iff (ext_rst)
    ps_cnt <= ps_term);

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (ext_rst)
    hold |=> (cnt_q == '0));
endmodule

bind wdog_prescaled wdog_prescaled_chk #(
  .MC_DIV(MC_DIV), .CNT_W(CNT_W), .PS_SEL_W(PS_SEL_W), .PULSE_MC(PULSE_MC)
) u_chk (
  .clk(clk), .ext_rst(ext_rst), .idle_i(idle_i), .cfg_we(cfg_we), .cfg_clr(cfg_clr),
  .wd_rst_o(wd_rst_o), .en_q(en_q), .idle_run_q(idle_run_q), .clr_q(clr_q),
  .mc_tick(mc_tick), .hold(hold), .cnt_q(cnt_q), .ps_cnt(ps_cnt), .ps_term(ps_term)
);

// File: tb/tb_wdog_prescaled.sv
module tb_wdog_prescaled;
  localparam int MC_DIV = 12;
  localparam int CNT_W  = 5;
  localparam int PULSE  = 2 * MC_DIV;

  logic clk = 1'b0, ext_rst = 1'b1, idle_i = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_clr = 1'b0, cfg_idle_run = 1'b0;
  logic [2:0] cfg_ps_sel = '0;
  logic clr_pending_o, wd_rst_o;
  int checks = 0, fails = 0, cycles = 0;

  wdog_prescaled #(.MC_DIV(MC_DIV), .CNT_W(CNT_W), .PS_SEL_W(3), .PULSE_MC(2)) dut (
    .clk(clk), .ext_rst(ext_rst), .idle_i(idle_i), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_clr(cfg_clr), .cfg_idle_run(cfg_idle_run), .cfg_ps_sel(cfg_ps_sel),
    .clr_pending_o(clr_pending_o), .wd_rst_o(wd_rst_o));

  always #5 clk = ~clk;

  function automatic int timeout(int sel);
    return (1 << CNT_W) * (2 << sel) * MC_DIV;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic apply_reset();
    @(negedge clk); ext_rst = 1'b1; idle_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pulse low in reset", wd_rst_o, 0);
    ext_rst = 1'b0;
    @(negedge clk);
    check("R1 clear low after reset", clr_pending_o, 0);
  endtask

  task automatic write_cfg(bit en, bit clr, bit irun, int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_clr = clr; cfg_idle_run = irun; cfg_ps_sel = 3'(sel);
    @(negedge clk);
    cfg_we = 1'b0; cfg_clr = 1'b0;
  endtask

  task automatic clear_wait(bit en, bit irun, int sel);
    int k = 0;
    write_cfg(en, 1'b1, irun, sel);
    check("R3 clear pending reads 1", clr_pending_o, 1);
    while (clr_pending_o && k <= MC_DIV) begin @(negedge clk); k++; end
    check("R3 clear self-cleared within a machine cycle", int'(k <= MC_DIV), 1);
  endtask

  task automatic wait_rise(output int n, input int limit);
    n = 0;
    while (!wd_rst_o && n <= limit) begin @(negedge clk); n++; end
  endtask

  task automatic t_timeout(int sel);
    int n, w, g;
    apply_reset();
    clear_wait(1'b1, 1'b0, sel);
    wait_rise(n, timeout(sel) + 100);
    check($sformatf("R2 timeout sel=%0d", sel), n, timeout(sel));
    w = 0;
    while (wd_rst_o && w <= 100) begin @(negedge clk); w++; end
    check("R7 pulse width", w, PULSE);
    if (sel == 0) begin
      wait_rise(g, timeout(sel) + 100);
      check("R9 restart from zero after pulse", g, timeout(sel));
      while (wd_rst_o) @(negedge clk);
    end
  endtask

  task automatic t_sel_change();
    int n;
    apply_reset();
    clear_wait(1'b1, 1'b0, 0);
    write_cfg(1'b1, 1'b0, 1'b0, 3);
    wait_rise(n, 8000);
    check("R8 select change at next terminal", n + 2, (2 + ((1 << CNT_W) - 1) * 16) * MC_DIV);
    while (wd_rst_o) @(negedge clk);
  endtask

  task automatic t_disabled();
    int seen = 0;
    apply_reset();
    clear_wait(1'b0, 1'b0, 0);
    repeat (3 * timeout(0)) begin @(negedge clk); if (wd_rst_o) seen++; end
    check("R5 no pulse when disabled", seen, 0);
  endtask

  task automatic t_idle();
    int seen = 0, n;
    apply_reset();
    clear_wait(1'b1, 1'b0, 0);
    idle_i = 1'b1;
    repeat (3 * timeout(0)) begin @(negedge clk); if (wd_rst_o) seen++; end
    check("R6 idle freezes count", seen, 0);
    write_cfg(1'b1, 1'b0, 1'b1, 0);
    wait_rise(n, timeout(0) + 100);
    check("R6 idle-run keeps counting", int'(n <= timeout(0) + 24), 1);
    while (wd_rst_o) @(negedge clk);
    idle_i = 1'b0;
  endtask

  task automatic t_kick();
    int seen = 0;
    apply_reset();
    clear_wait(1'b1, 1'b0, 0);
    repeat (6) begin
      repeat (500) begin @(negedge clk); if (wd_rst_o) seen++; end
      clear_wait(1'b1, 1'b0, 0);
    end
    check("R4 periodic clears prevent reset", seen, 0);
  endtask

  initial begin
    t_timeout(0);
    t_timeout(1);
    t_timeout(4);
    t_sel_change();
    t_disabled();
    t_idle();
    t_kick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule